// File: doc/BRIEF.md
# Timer Event Flag Register Block

This block keeps the pending-event flags of a 16-bit timer. Six channel flags record capture or compare events, and one overflow flag records each rollover of the free-running counter. It sits on a simple byte-wide register bus. Software reads the flags and clears them by writing ones. An optional fast-clear mode instead clears a flag as a side effect of the ordinary access that services its event: reading a capture value, writing a compare value, or touching the counter.

Each flag drives an interrupt request, gated by its own enable input. The bus has no back-pressure. Every access completes in the cycle its strobe is high. Read data is valid in that same cycle, and clear side effects show on the flags after the next rising edge. The event pulses, counter value and mode bits are plain level or pulse inputs sampled on every edge.

Top module: `tmr_flag_ctl`

## Requirements
- R1: After reset, every channel flag, the overflow flag and every interrupt request is 0.
- R2: A high `chan_evt[i]` at a clock edge makes `chan_flag[i]` 1 after that edge. A set and a clear of the same flag at the same edge leave the flag at 1, and the same holds for the overflow flag.
- R3: A write to offset 0x0E clears each channel flag i whose data bit i is 1, but only while `tmr_en` is 1. Zero data bits, and all writes made while `tmr_en` is 0, leave the flags unchanged.
- R4: A write to offset 0x0F with data bit 7 set clears the overflow flag while `tmr_en` is 1. Data bits 6:0 have no effect, and the write does nothing while `tmr_en` is 0.
- R5: The overflow flag is set only when `cnt_val` is 0xFFFF at one clock edge and 0x0000 at the next edge. No other pair of consecutive values sets it.
- R6: During a read, `bus_rdata` is {2'b00, channel flags} at 0x0E and {overflow flag, 7'b0} at 0x0F. At every other address, and whenever `bus_rd` is 0, `bus_rdata` is 0.
- R7: Channel i owns offsets 0x10+2i and 0x11+2i. With `fast_clr` = 1, a read of either offset clears flag i when `chan_mode_oc[i]` = 0 (capture), and a write clears it when `chan_mode_oc[i]` = 1 (compare). The opposite access type does not clear the flag, and with `fast_clr` = 0 neither access type clears it.
- R8: With `fast_clr` = 1, any read or write at offset 0x04 or 0x05 clears the overflow flag, whatever the value of `tmr_en`. With `fast_clr` = 0, such accesses do nothing.
- R9: `chan_irq[i]` equals `chan_flag[i]` AND `chan_ie[i]`, and `ovf_irq` equals the overflow flag AND `ovf_ie`.
- R10: Accesses to any other offset, including 0x1C–0x1F, change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| chan_evt | input | 6 | Per-channel capture/compare event pulses |
| chan_mode_oc | input | 6 | 1 = channel is in compare mode, 0 = capture mode |
| cnt_val | input | 16 | Free-running counter value |
| tmr_en | input | 1 | Timer enable; gates write-one-to-clear |
| fast_clr | input | 1 | Fast-clear mode select |
| chan_ie | input | 6 | Channel interrupt enables |
| ovf_ie | input | 1 | Overflow interrupt enable |
| chan_flag | output | 6 | Channel flags |
| ovf_flag | output | 1 | Overflow flag |
| chan_irq | output | 6 | Channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench walks all 64 offsets with reads and with writes, under both fast-clear settings and several capture/compare mode patterns. A decoder that mapped a channel to the wrong byte pair, or that cleared on the wrong access type, would wipe flags it should keep. It also sweeps every data pattern for both flag registers with the enable on and off. A design that ignored the enable gate, or that honoured bit 6:0 writes to the overflow register, would lose events. Same-edge set/clear collisions are driven on purpose: a design where the clear wins would drop an event. Counter sequences that brush past 0xFFFF without landing on 0x0000 must not raise the overflow flag.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_FLG_CH  = 6'h0E;
  localparam logic [ADDR_W-1:0] ADR_FLG_OVF = 6'h0F;
  localparam logic [ADDR_W-1:0] ADR_CH_BASE = 6'h10;
endpackage

// File: rtl/tmr_clr_dec.sv
module tmr_clr_dec
  import tmr_flag_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [NCH-1:0]    wr_mask,
  input  logic              wr_ovf_bit,
  input  logic [NCH-1:0]    chan_mode_oc,
  input  logic              tmr_en,
  input  logic              fast_clr,
  output logic [NCH-1:0]    chan_clr,
  output logic              ovf_clr
);
  logic [NCH-1:0] fast_hit;
  logic           sw_ch_wr;
  logic           sw_ovf_wr;
  logic           cnt_touch;

  // each channel owns a two-byte window; bit 0 of the offset picks the byte
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] WIN = ADR_CH_BASE + ADDR_W'(2 * i);
    logic in_win;
    assign in_win      = (bus_addr[ADDR_W-1:1] == WIN[ADDR_W-1:1]);
    assign fast_hit[i] = fast_clr && in_win &&
                         ((bus_rd && !chan_mode_oc[i]) || (bus_wr && chan_mode_oc[i]));
  end

  assign sw_ch_wr  = bus_wr && tmr_en && (bus_addr == ADR_FLG_CH);
  assign sw_ovf_wr = bus_wr && tmr_en && (bus_addr == ADR_FLG_OVF) && wr_ovf_bit;
  assign cnt_touch = fast_clr && (bus_rd || bus_wr) &&
                     (bus_addr[ADDR_W-1:1] == ADR_CNT_HI[ADDR_W-1:1]);

  assign chan_clr = ({NCH{sw_ch_wr}} & wr_mask) | fast_hit;
  assign ovf_clr  = sw_ovf_wr || cnt_touch;
endmodule

// File: rtl/tmr_wrap_det.sv
module tmr_wrap_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             wrap
);
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt_val;
  end

  assign wrap = (prev_q == {CNT_W{1'b1}}) && (cnt_val == '0);
endmodule

// File: rtl/tmr_flag_bits.sv
module tmr_flag_bits #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;   // set has priority over clear
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl
  import tmr_flag_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    chan_evt,
  input  logic [NCH-1:0]    chan_mode_oc,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              tmr_en,
  input  logic              fast_clr,
  input  logic [NCH-1:0]    chan_ie,
  input  logic              ovf_ie,
  output logic [NCH-1:0]    chan_flag,
  output logic              ovf_flag,
  output logic [NCH-1:0]    chan_irq,
  output logic              ovf_irq
);
  logic [NCH-1:0] chan_clr;
  logic           ovf_clr;
  logic           wrap;
  logic           unused_wdata;

  assign unused_wdata = ^bus_wdata;

  tmr_clr_dec #(.NCH(NCH)) u_dec (
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .wr_mask     (bus_wdata[NCH-1:0]),
    .wr_ovf_bit  (bus_wdata[DATA_W-1]),
    .chan_mode_oc(chan_mode_oc),
    .tmr_en      (tmr_en),
    .fast_clr    (fast_clr),
    .chan_clr    (chan_clr),
    .ovf_clr     (ovf_clr)
  );

  tmr_wrap_det #(.CNT_W(CNT_W)) u_wrap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_val(cnt_val),
    .wrap   (wrap)
  );

  tmr_flag_bits #(.W(NCH)) u_chflags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (chan_evt),
    .clr  (chan_clr),
    .q    (chan_flag)
  );

  tmr_flag_bits #(.W(1)) u_ovflag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (wrap),
    .clr  (ovf_clr),
    .q    (ovf_flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADR_FLG_CH)       bus_rdata[NCH-1:0]  = chan_flag;
      else if (bus_addr == ADR_FLG_OVF) bus_rdata[DATA_W-1] = ovf_flag;
    end
  end

  assign chan_irq = chan_flag & chan_ie;
  assign ovf_irq  = ovf_flag & ovf_ie;
endmodule

// File: rtl/tmr_flag_ctl_chk.sv
module tmr_flag_ctl_chk #(
  parameter int NCH   = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [7:0]       bus_rdata,
  input logic [NCH-1:0]   chan_evt,
  input logic [NCH-1:0]   chan_mode_oc,
  input logic [CNT_W-1:0] cnt_val,
  input logic             tmr_en,
  input logic             fast_clr,
  input logic [NCH-1:0]   chan_flag,
  input logic             ovf_flag
);
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_evt) |=> ((chan_flag & $past(chan_evt)) == $past(chan_evt)));

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !fast_clr) |=>
      (((chan_flag & $past(chan_flag)) == $past(chan_flag)) && (ovf_flag || !$past(ovf_flag))));

  a_r5_set_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !$past(ovf_flag)) |-> ($past(cnt_val) == '0));

  a_r6_ovf_reg_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h0F) |-> (bus_rdata[6:0] == 7'd0));

  a_r6_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'd0));

  a_r7_capture_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && bus_rd && bus_addr == 6'h10 && !chan_mode_oc[0] && !chan_evt[0]) |=> !chan_flag[0]);

  a_r8_counter_touch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && (bus_rd || bus_wr) && bus_addr == 6'h04 && cnt_val != '0) |=> !ovf_flag);
endmodule

bind tmr_flag_ctl tmr_flag_ctl_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_rdata   (bus_rdata),
  .chan_evt    (chan_evt),
  .chan_mode_oc(chan_mode_oc),
  .cnt_val     (cnt_val),
  .tmr_en      (tmr_en),
  .fast_clr    (fast_clr),
  .chan_flag   (chan_flag),
  .ovf_flag    (ovf_flag)
);

// File: tb/tmr_flag_ctl_bench.sv
`timescale 1ns/1ps
module tmr_flag_ctl_bench;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0]     bus_addr = '0;
  logic           bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] chan_evt = '0, chan_mode_oc = '0, chan_ie = '0;
  logic [15:0]    cnt_val = '0;
  logic           tmr_en = 1'b0, fast_clr = 1'b0, ovf_ie = 1'b0;
  logic [NCH-1:0] chan_flag, chan_irq;
  logic           ovf_flag, ovf_irq;

  tmr_flag_ctl u_tmr_flag_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_evt(chan_evt),
    .chan_mode_oc(chan_mode_oc), .cnt_val(cnt_val), .tmr_en(tmr_en), .fast_clr(fast_clr),
    .chan_ie(chan_ie), .ovf_ie(ovf_ie), .chan_flag(chan_flag), .ovf_flag(ovf_flag),
    .chan_irq(chan_irq), .ovf_irq(ovf_irq)
  );

  int checks = 0;
  int fails = 0;
  logic [NCH-1:0] m_chan = '0;
  logic           m_ovf = 1'b0;
  logic [15:0]    m_prev = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(logic [5:0] a);
    if (a == 6'h0E) return {2'b00, m_chan};
    if (a == 6'h0F) return {m_ovf, 7'b0};
    return 8'h00;
  endfunction

  // one bus cycle: drive at negedge, check read data, let the edge pass, check flags
  task automatic step(string tag, logic [5:0] a, logic rd, logic wr, logic [7:0] wd,
                      logic [NCH-1:0] evt, logic [15:0] cnt);
    logic [NCH-1:0] c;
    logic oclr, oset;
    int ch;
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; chan_evt = evt; cnt_val = cnt;
    #1;
    chk(rd ? "R6 read data" : "R6 idle data", bus_rdata, rd ? exp_rdata(a) : 8'h00);
    c = '0;
    if (wr && a == 6'h0E && tmr_en) c = wd[NCH-1:0];
    if (fast_clr && a >= 6'h10 && a < 6'h10 + 6'(2*NCH)) begin
      ch = (int'(a) - 16) / 2;
      if ((rd && !chan_mode_oc[ch]) || (wr && chan_mode_oc[ch])) c[ch] = 1'b1;
    end
    oclr = (wr && a == 6'h0F && tmr_en && wd[7]) ||
           (fast_clr && (rd || wr) && (a == 6'h04 || a == 6'h05));
    oset = (m_prev == 16'hFFFF) && (cnt == 16'h0000);
    @(posedge clk);
    #1;
    m_chan = (m_chan & ~c) | evt;
    m_ovf  = (m_ovf && !oclr) || oset;
    m_prev = cnt;
    chk({tag, " flags"}, {ovf_flag, chan_flag}, {m_ovf, m_chan});
    chk("R9 irq", {ovf_irq, chan_irq}, {m_ovf & ovf_ie, m_chan & chan_ie});
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; chan_evt = '0;
  endtask

  task automatic set_all();
    step("R2", 6'h00, 1'b0, 1'b0, 8'h00, '1, 16'hFFFF);
    step("R5", 6'h00, 1'b0, 1'b0, 8'h00, '0, 16'h0000);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NCH-1:0] pats [3];
    pats[0] = '0; pats[1] = '1; pats[2] = 6'b010101;
    repeat (3) @(negedge clk);
    chk("R1 reset flags", {ovf_flag, chan_flag}, '0);
    chk("R1 reset irq", {ovf_irq, chan_irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after release", {ovf_flag, chan_flag}, '0);

    // R5: counter sequences around the rollover point
    begin
      logic [15:0] seq [10];
      seq = '{16'hFFFE, 16'hFFFF, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h0000,
              16'h0000, 16'h8000, 16'hFFFF, 16'h0000};
      for (int i = 0; i < 10; i++) step("R5", 6'h00, 1'b0, 1'b0, 8'h00, '0, seq[i]);
    end

    // R3: every data pattern to the channel flag register, enable off and on
    for (int en = 0; en < 2; en++) begin
      tmr_en = en[0];
      for (int wd = 0; wd < 64; wd++) begin
        set_all();
        step("R3", 6'h0E, 1'b0, 1'b1, 8'(wd), '0, 16'h0001);
      end
    end

    // R4: every data pattern to the overflow register
    for (int en = 0; en < 2; en++) begin
      tmr_en = en[0];
      for (int wd = 0; wd < 256; wd++) begin
        set_all();
        step("R4", 6'h0F, 1'b0, 1'b1, 8'(wd), '0, 16'h0001);
      end
    end

    // R7 R8 R10: all offsets, reads and writes with zero data, fast-clear off and on
    tmr_en = 1'b0;
    for (int fc = 0; fc < 2; fc++) begin
      fast_clr = fc[0];
      for (int p = 0; p < 3; p++) begin
        chan_mode_oc = pats[p];
        for (int a = 0; a < 64; a++) begin
          for (int k = 0; k < 2; k++) begin
            set_all();
            if (a >= 16 && a < 16 + 2*NCH)
              step("R7", 6'(a), k == 0, k == 1, 8'h00, '0, 16'h0002);
            else if (a == 4 || a == 5)
              step("R8", 6'(a), k == 0, k == 1, 8'h00, '0, 16'h0002);
            else
              step("R10", 6'(a), k == 0, k == 1, 8'h00, '0, 16'h0002);
          end
        end
      end
    end

    // R2: set and clear of the same flag at the same edge
    tmr_en = 1'b1; fast_clr = 1'b1; chan_mode_oc = '0;
    set_all();
    step("R2 collide sw", 6'h0E, 1'b0, 1'b1, 8'h3F, 6'b100001, 16'h0003);
    step("R2 collide fast", 6'h12, 1'b1, 1'b0, 8'h00, 6'b000010, 16'h0004);
    step("R2 pre", 6'h00, 1'b0, 1'b0, 8'h00, '0, 16'hFFFF);
    step("R2 ovf collide", 6'h0F, 1'b0, 1'b1, 8'h80, '0, 16'h0000);
    step("R2 pre", 6'h00, 1'b0, 1'b0, 8'h00, '0, 16'hFFFF);
    step("R2 ovf collide fast", 6'h05, 1'b1, 1'b0, 8'h00, '0, 16'h0000);

    // R9: interrupt enable sweep over a mixed flag state
    set_all();
    step("R9 mix", 6'h0E, 1'b0, 1'b1, 8'h15, '0, 16'h0005);
    for (int ie = 0; ie < 128; ie++) begin
      chan_ie = ie[5:0]; ovf_ie = ie[6];
      step("R9", 6'h00, 1'b0, 1'b0, 8'h00, '0, 16'h0006);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule